// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives the scan of a display controller. Software loads the horizontal and vertical timing, the frame buffer start address, the line pitch, the visible line count and the pixel depth through a small write-only register port. The block runs a horizontal pixel counter and a vertical line counter. From them it produces the blanking flags, an active-video flag, active-high sync pulses, a pixel-valid strobe and the byte address to read from the frame buffer for the current pixel. Clock generation, the memory fetch, the palette and the DAC belong to other blocks.

Each axis is set by two packed words. The blanking word holds the last counter value of the line or frame in its upper half and the last active value in its lower half. The sync word holds two compare values, one in each half. For an axis with active size A, front porch F, sync length S and back porch B, software writes {A+F+S+B-1, A-1} as the blanking word and {A+F+S-1, A+F-1} as the sync word. For example, a 640x480 mode with porches 16/96/48 and 10/2/33 gives {799, 639} and {751, 655} horizontally, and {524, 479} and {491, 489} vertically.

A two-state machine controls the scan. In `ST_OFF` the counters are cleared and every write reaches the working copy of the settings at once. In `ST_RUN` the counters advance and the working copy is refreshed only at the frame boundary. The transition `ST_OFF -> ST_RUN` is taken on a clock edge when the enable bit is set. The transition `ST_RUN -> ST_OFF` is taken on a clock edge when the enable bit is clear.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, both counters read zero, both blanking flags are high, and `video_on`, `h_sync`, `v_sync` and `pix_valid` are low.
- R2: When enabled, `h_count` steps by one on every clock from 0 up to the upper half (bits 31:16) of the horizontal blanking word, then returns to 0. `v_count` steps by one each time `h_count` returns to 0 and wraps the same way at the upper half of the vertical blanking word.
- R3: `h_blank` (`v_blank`) is high exactly when the counter is greater than the lower half (bits 15:0) of its blanking word. `video_on` is high when both blanking flags are low.
- R4: `h_sync` (`v_sync`) is high exactly when its counter is greater than the lower half of its sync word and not greater than the upper half.
- R5: `pix_valid` is high when `video_on` is high and `v_count` is below the visible line count register.
- R6: While `pix_valid` is high, `rd_addr` equals base + `v_count`·pitch·8 + `h_count`·N. N is set by the depth field: code 0 gives N=1, 1 gives 2, 2 gives 3, and 3 gives 4.
- R7: While running, a write to the base, pitch, line count or any timing word changes the outputs only from the first cycle of the next frame, the cycle in which both counters are zero. While disabled, every write applies before counting starts.
- R8: Clearing the enable bit drives `video_on`, `h_sync`, `v_sync` and `pix_valid` low in the cycle after the write, and both counters read zero from the cycle after that. Setting the enable bit makes the counters read 0 in the second cycle after the write and 1 in the third cycle.
- R9: The register index is `wr_addr`: 0 is control (bit 0 enable, bits 2:1 depth code), 1 is base, 2 is pitch in 8-byte units, 3 is visible line count, 4 is horizontal blanking, 5 is horizontal sync, 6 is vertical blanking, and 7 is vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Write data |
| h_count | output | 16 | Horizontal pixel counter |
| v_count | output | 16 | Vertical line counter |
| h_blank | output | 1 | Horizontal blanking flag |
| v_blank | output | 1 | Vertical blanking flag |
| video_on | output | 1 | Active video region |
| h_sync | output | 1 | Horizontal sync, active high |
| v_sync | output | 1 | Vertical sync, active high |
| pix_valid | output | 1 | Pixel fetch strobe |
| rd_addr | output | 32 | Frame buffer byte address |

## Verification
A wrong counter value shows on `h_count` or `v_count` in the same cycle. It also shifts every later flag, sync pulse and address, so a single error persists until the next frame boundary at the latest. An error in the line base register appears in `rd_addr` on the first valid pixel of the next line. A working copy that refreshes at the wrong moment shows as a line length that changes in the middle of a frame, on the first line after the write. The bench compares every output on every cycle of whole frames against a model built from the requirements, so any of these faults is reported within one frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int REG_W   = 32;
    localparam int CNT_W   = REG_W / 2;
    localparam int ADDR_W  = 32;
    localparam int RIDX_W  = 3;
    localparam int PITCH_SHIFT = 3;

    typedef enum logic [1:0] {
        PIX8  = 2'd0,
        PIX16 = 2'd1,
        PIX24 = 2'd2,
        PIX32 = 2'd3
    } pix_depth_e;

    typedef enum logic [RIDX_W-1:0] {
        RG_CTRL  = 3'd0,
        RG_BASE  = 3'd1,
        RG_PITCH = 3'd2,
        RG_LINES = 3'd3,
        RG_HBLK  = 3'd4,
        RG_HSYN  = 3'd5,
        RG_VBLK  = 3'd6,
        RG_VSYN  = 3'd7
    } reg_idx_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] tot_m1;
        logic [CNT_W-1:0] act_m1;
        logic [CNT_W-1:0] syn_hi;
        logic [CNT_W-1:0] syn_lo;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t         h;
        axis_cfg_t         v;
        pix_depth_e        depth;
        logic [ADDR_W-1:0] base;
        logic [REG_W-1:0]  pitch;
        logic [REG_W-1:0]  lines;
    } scan_cfg_t;

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ctl_en_d,
    input  pix_depth_e        ctl_depth_d,
    input  logic              load,
    output logic              en_live,
    output scan_cfg_t         pend,
    output scan_cfg_t         shd
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_live <= 1'b0;
            pend    <= '0;
        end else if (wr_en) begin
            unique case (reg_idx_e'(wr_addr))
                RG_CTRL: begin
                    en_live    <= ctl_en_d;
                    pend.depth <= ctl_depth_d;
                end
                RG_BASE:  pend.base  <= wr_data;
                RG_PITCH: pend.pitch <= wr_data;
                RG_LINES: pend.lines <= wr_data;
                RG_HBLK:  {pend.h.tot_m1, pend.h.act_m1} <= wr_data;
                RG_HSYN:  {pend.h.syn_hi, pend.h.syn_lo} <= wr_data;
                RG_VBLK:  {pend.v.tot_m1, pend.v.act_m1} <= wr_data;
                RG_VSYN:  {pend.v.syn_hi, pend.v.syn_lo} <= wr_data;
            endcase
        end
    end

    // Working copy: follows the pending set only at frame boundaries or while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd <= '0;
        end else if (load) begin
            shd <= pend;
        end
    end

endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             blank,
    output logic             sync
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        last  = (cnt == cfg.tot_m1);
        blank = (cnt > cfg.act_m1);
        sync  = (cnt > cfg.syn_lo) && (cnt <= cfg.syn_hi);
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (cnt == '0));

    // R2
    within_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt <= cfg.tot_m1));

endmodule

// File: rtl/dtg_addr.sv
module dtg_addr
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              line_end,
    input  logic [ADDR_W-1:0] base_next,
    input  logic [REG_W-1:0]  pitch,
    input  pix_depth_e        depth,
    input  logic [CNT_W-1:0]  h_cnt,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int PAD_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] line_base;
    logic [ADDR_W-1:0] h_ext;
    logic [ADDR_W-1:0] pix_off;
    logic [ADDR_W-1:0] line_step;

    assign h_ext     = {{PAD_W{1'b0}}, h_cnt};
    assign line_step = ADDR_W'(pitch) << PITCH_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_base <= '0;
        end else if (load) begin
            line_base <= base_next;
        end else if (line_end) begin
            line_base <= line_base + line_step;
        end
    end

    always_comb begin
        unique case (depth)
            PIX8:  pix_off = h_ext;
            PIX16: pix_off = h_ext << 1;
            PIX24: pix_off = (h_ext << 1) + h_ext;
            PIX32: pix_off = h_ext << 2;
        endcase
    end

    assign rd_addr = line_base + pix_off;

    // R6
    line_base_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (line_base == $past(base_next)));

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  h_count,
    output logic [CNT_W-1:0]  v_count,
    output logic              h_blank,
    output logic              v_blank,
    output logic              video_on,
    output logic              h_sync,
    output logic              v_sync,
    output logic              pix_valid,
    output logic [ADDR_W-1:0] rd_addr
);

    scan_state_e state, state_nx;
    scan_cfg_t   pend, shd;
    logic        en_live, run, load, frame_end;
    logic        h_last, v_last, h_bl, v_bl, h_sy, v_sy;

    dtg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ctl_en_d    (wr_data[0]),
        .ctl_depth_d (pix_depth_e'(wr_data[2:1])),
        .load        (load),
        .en_live     (en_live),
        .pend        (pend),
        .shd         (shd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        unique case (state)
            ST_OFF: state_nx = en_live ? ST_RUN : ST_OFF;
            ST_RUN: state_nx = en_live ? ST_RUN : ST_OFF;
        endcase
    end

    assign run       = (state == ST_RUN) && en_live;
    assign frame_end = run && h_last && v_last;
    assign load      = !run || frame_end;

    dtg_axis u_hax (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .step  (run),
        .cfg   (shd.h),
        .cnt   (h_count),
        .last  (h_last),
        .blank (h_bl),
        .sync  (h_sy)
    );

    dtg_axis u_vax (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .step  (run && h_last),
        .cfg   (shd.v),
        .cnt   (v_count),
        .last  (v_last),
        .blank (v_bl),
        .sync  (v_sy)
    );

    dtg_addr u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .line_end  (run && h_last),
        .base_next (pend.base),
        .pitch     (shd.pitch),
        .depth     (shd.depth),
        .h_cnt     (h_count),
        .rd_addr   (rd_addr)
    );

    // Outputs
    always_comb begin
        h_blank   = !run || h_bl;
        v_blank   = !run || v_bl;
        video_on  = run && !h_bl && !v_bl;
        h_sync    = run && h_sy;
        v_sync    = run && v_sy;
        pix_valid = video_on && (REG_W'(v_count) < shd.lines);
    end

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!h_sync && !v_sync && !pix_valid && !video_on));

    // R8
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (h_count == '0 && v_count == '0));

    // R5
    valid_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (video_on && !h_blank && !v_blank));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (h_count != '0 || v_count != '0)) |-> $stable(shd));

endmodule

// File: tb/sim_disp_timing_gen.sv
module sim_disp_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] h_count, v_count;
    logic        h_blank, v_blank, video_on, h_sync, v_sync, pix_valid;
    logic [31:0] rd_addr;

    always #5 clk = ~clk;

    disp_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .h_count(h_count), .v_count(v_count), .h_blank(h_blank), .v_blank(v_blank),
        .video_on(video_on), .h_sync(h_sync), .v_sync(v_sync),
        .pix_valid(pix_valid), .rd_addr(rd_addr)
    );

    typedef struct {
        int ht, ha, hl, hh, vt, va, vl, vh, bytes, base, pitch, lines;
    } mcfg_t;

    // hact hfp hsy hbp vact vfp vsy vbp depth pitch lines base
    localparam int NVEC = 4;
    localparam int VEC [NVEC][12] = '{
        '{6, 2, 2, 3, 4, 1, 1, 2, 0, 2, 4, 'h100},
        '{8, 1, 3, 1, 3, 2, 2, 1, 1, 3, 3, 'h2000},
        '{5, 2, 1, 2, 5, 1, 2, 1, 2, 4, 3, 'h40},
        '{4, 1, 1, 1, 2, 1, 1, 1, 3, 1, 2, 'h0}
    };

    int n_chk = 0, n_bad = 0;
    mcfg_t cur, nxt;
    int mh = 0, mv = 0;

    task automatic chk(string rq, string nm, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, nm, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R9 register indices; R7 writes while disabled apply before counting
    task automatic program_vec(int i);
        int ha, hf, hs, hb, va, vf, vs, vb;
        ha = VEC[i][0]; hf = VEC[i][1]; hs = VEC[i][2]; hb = VEC[i][3];
        va = VEC[i][4]; vf = VEC[i][5]; vs = VEC[i][6]; vb = VEC[i][7];
        cur.ht = ha + hf + hs + hb - 1; cur.ha = ha - 1;
        cur.hl = ha + hf - 1;           cur.hh = ha + hf + hs - 1;
        cur.vt = va + vf + vs + vb - 1; cur.va = va - 1;
        cur.vl = va + vf - 1;           cur.vh = va + vf + vs - 1;
        cur.bytes = VEC[i][8] + 1; cur.pitch = VEC[i][9];
        cur.lines = VEC[i][10];    cur.base = VEC[i][11];
        nxt = cur;
        wr(0, 32'd0);
        wr(1, cur.base);
        wr(2, cur.pitch);
        wr(3, cur.lines);
        wr(4, {cur.ht[15:0], cur.ha[15:0]});
        wr(5, {cur.hh[15:0], cur.hl[15:0]});
        wr(6, {cur.vt[15:0], cur.va[15:0]});
        wr(7, {cur.vh[15:0], cur.vl[15:0]});
        wr(0, (VEC[i][8] << 1) | 1);
        @(negedge clk);
        mh = 0; mv = 0;
    endtask

    task automatic compare(string tag);
        bit hb, vb, hs, vs, vld;
        hb  = mh > cur.ha;
        vb  = mv > cur.va;
        hs  = (mh > cur.hl) && (mh <= cur.hh);
        vs  = (mv > cur.vl) && (mv <= cur.vh);
        vld = !hb && !vb && (mv < cur.lines);
        chk(tag == "" ? "R2" : tag, "h_count", h_count, mh);
        chk(tag == "" ? "R2" : tag, "v_count", v_count, mv);
        chk(tag == "" ? "R3" : tag, "h_blank", h_blank, hb);
        chk(tag == "" ? "R3" : tag, "v_blank", v_blank, vb);
        chk(tag == "" ? "R3" : tag, "video_on", video_on, !hb && !vb);
        chk(tag == "" ? "R4" : tag, "h_sync", h_sync, hs);
        chk(tag == "" ? "R4" : tag, "v_sync", v_sync, vs);
        chk(tag == "" ? "R5" : tag, "pix_valid", pix_valid, vld);
        if (vld)
            chk(tag == "" ? "R6" : tag, "rd_addr", rd_addr,
                cur.base + mv * cur.pitch * 8 + mh * cur.bytes);
    endtask

    task automatic advance();
        if (mh == cur.ht) begin
            mh = 0;
            if (mv == cur.vt) begin
                mv = 0;
                cur = nxt;
            end else begin
                mv++;
            end
        end else begin
            mh++;
        end
    endtask

    // Checks n cycles; optionally writes a horizontal blanking word at cycle wat
    task automatic run_cycles(int n, string tag, int wat, logic [31:0] wd);
        for (int i = 0; i < n; i++) begin
            compare(tag);
            if (i == wat) begin
                wr_en = 1'b1; wr_addr = 3'd4; wr_data = wd;
            end
            @(negedge clk);
            wr_en = 1'b0;
            advance();
            if (i == wat) begin
                nxt.ht = wd[31:16];
                nxt.ha = wd[15:0];
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "h_count", h_count, 0);
        chk("R1", "v_count", v_count, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "h_count", h_count, 0);
        chk("R1", "v_count", v_count, 0);
        chk("R1", "h_blank", h_blank, 1);
        chk("R1", "v_blank", v_blank, 1);
        chk("R1", "video_on", video_on, 0);
        chk("R1", "syncs", {h_sync, v_sync}, 0);
        chk("R1", "pix_valid", pix_valid, 0);

        // Vector table: two whole frames per configuration
        for (int i = 0; i < NVEC; i++) begin
            program_vec(i);
            run_cycles(2 * (cur.ht + 1) * (cur.vt + 1), "", -1, 32'd0);
        end

        // R7 mid-frame rewrite of the horizontal total is deferred to the next frame
        program_vec(0);
        run_cycles(3 * 13 * 8, "R7", 20, {16'd15, 16'd5});

        // R8 disable mid-frame
        program_vec(1);
        run_cycles(7, "", -1, 32'd0);
        wr(0, 32'd0);
        chk("R8", "video_on", video_on, 0);
        chk("R8", "syncs", {h_sync, v_sync}, 0);
        chk("R8", "pix_valid", pix_valid, 0);
        @(negedge clk);
        chk("R8", "h_count", h_count, 0);
        chk("R8", "v_count", v_count, 0);
        repeat (4) @(negedge clk);
        chk("R8", "h_count_held", h_count, 0);
        // R8 re-enable: 0 in the second cycle, 1 in the third
        wr(0, 32'd3);
        chk("R8", "h_count_pre", h_count, 0);
        @(negedge clk);
        chk("R8", "h_count_start", h_count, 0);
        chk("R8", "video_on_start", video_on, 1);
        @(negedge clk);
        chk("R8", "h_count_step", h_count, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule